// File: doc/BRIEF.md
# AXI4-Lite Link Rule Monitor

This block listens to a memory-mapped AXI4-Lite link without driving any of its signals. It watches all five channels: read request, read return, write request, write data and write acknowledge. It checks the handshake and ordering rules on every clock edge. Each rule has its own sticky error flag, so a log of the link shows which rule broke and on which channel.

A transfer counts only on an edge where the VALID and READY of that channel are both high. The monitor keeps a 16-bit count of transfers per channel. It also keeps small outstanding counters, one for read requests and one each for write requests and write data. These let it judge whether a read return or a write acknowledge came too early.

A one-cycle pulse marks every cycle in which a new violation was seen. A combined output shows that at least one flag is set. Software or a test harness clears the flags with a synchronous clear input.

Top module: `axl_rule_mon`

## Requirements
- R1: Each channel's transfer counter (`cnt_ar`, `cnt_r`, `cnt_aw`, `cnt_w`, `cnt_b`) rises by one for each edge outside reset where that channel's VALID and READY are both high. The counters wrap from 65535 to 0 and read 0 after reset.
- R2: If a VALID was high with READY low at one edge and is low at the next edge, the channel's drop flag is set. The drop flags are `err_flags` bit 0 (read request), bit 1 (read return), bit 2 (write request), bit 3 (write data) and bit 4 (write acknowledge).
- R3: If a VALID was high with READY low at one edge, is still high at the next edge and its payload has changed, the channel's payload flag is set. The payload flags are bits 5 to 9, in the same channel order as R2. The payloads are address with protection, read data with response, write data with strobe, and the write response.
- R4: Bit 10 is set when `rvalid` is high while no read request is outstanding. A read request handshake on the same edge does not count as outstanding. A read return handshake with none outstanding also sets bit 10.
- R5: Bit 11 is set when `bvalid` is high while there is not both an outstanding write request and outstanding write data. It is also set when a write acknowledge handshake finds either of these counters empty.
- R6: A response code of 01 on `rresp` while `rvalid` is high sets bit 12. A response code of 01 on `bresp` while `bvalid` is high sets bit 13. The codes 00, 10 and 11 are legal.
- R7: The outstanding counters hold at most 15 entries. A request handshake on a full counter, with no matching response on the same edge, sets bit 14 (read) or bit 15 (write request or write data). The counter then stays at 15.
- R8: Reset is synchronous and active high. During reset, bit 16 records whether any VALID is high, and all other flags clear. Rule checks are masked on the first edge after reset is released.
- R9: Flags stay set until an edge with `err_clr` high. That edge loads only the violations seen on that same edge. `err_any` is the OR of all flags.
- R10: `err_pulse` is high for exactly the cycle after each edge that detected at least one new violation, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Clears the sticky flags |
| araddr | input | 32 | Read request address |
| arprot | input | 3 | Read request protection |
| arvalid | input | 1 | Read request VALID |
| arready | input | 1 | Read request READY |
| rdata | input | 32 | Read return data |
| rresp | input | 2 | Read return response |
| rvalid | input | 1 | Read return VALID |
| rready | input | 1 | Read return READY |
| awaddr | input | 32 | Write request address |
| awprot | input | 3 | Write request protection |
| awvalid | input | 1 | Write request VALID |
| awready | input | 1 | Write request READY |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data VALID |
| wready | input | 1 | Write data READY |
| bresp | input | 2 | Write acknowledge response |
| bvalid | input | 1 | Write acknowledge VALID |
| bready | input | 1 | Write acknowledge READY |
| err_flags | output | 17 | Sticky per-rule flags |
| err_any | output | 1 | OR of all flags |
| err_pulse | output | 1 | New violation on the previous edge |
| cnt_ar | output | 16 | Read request transfers |
| cnt_r | output | 16 | Read return transfers |
| cnt_aw | output | 16 | Write request transfers |
| cnt_w | output | 16 | Write data transfers |
| cnt_b | output | 16 | Write acknowledge transfers |

## Verification
A violation present on the bus before a rising edge shows up in `err_flags` and `err_pulse` right after that edge. A handshake on an edge raises its transfer counter after that same edge. No result takes more than one register stage.

The bench changes its inputs only on falling edges. It compares every output with its behavioural model on the falling edge that follows each rising edge, so each result is read half a cycle after it becomes due. The model is built from queues and integers.

The masked cycle after reset and the clear edge are both exercised. In each case a violation is deliberately placed in the same cycle, so the exact cycle boundary is tested.

// File: rtl/axl_mon_pkg.sv
package axl_mon_pkg;

    localparam int CH_NUM = 5;
    localparam int IX_AR  = 0;
    localparam int IX_R   = 1;
    localparam int IX_AW  = 2;
    localparam int IX_W   = 3;
    localparam int IX_B   = 4;

    localparam int ERR_DROP_BASE = 0;
    localparam int ERR_UNST_BASE = 5;
    localparam int ERR_RD_EARLY  = 10;
    localparam int ERR_WR_EARLY  = 11;
    localparam int ERR_R_EXOK    = 12;
    localparam int ERR_B_EXOK    = 13;
    localparam int ERR_RD_DEEP   = 14;
    localparam int ERR_WR_DEEP   = 15;
    localparam int ERR_RST_VALID = 16;
    localparam int ERR_NUM       = 17;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

    typedef struct packed {
        logic fire;
        logic drop;
        logic unstable;
    } chan_evt_t;

    function automatic logic resp_illegal(input logic [1:0] code);
        return resp_e'(code) == RESP_EXOKAY;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/axl_chan_watch.sv
module axl_chan_watch
    import axl_mon_pkg::*;
#(
    parameter int PAY_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             ready,
    input  logic [PAY_W-1:0] payload,
    output chan_evt_t        evt,
    output logic [CNT_W-1:0] count
);

    logic             valid_q;
    logic             ready_q;
    logic [PAY_W-1:0] pay_q;
    logic             waiting;

    // A transfer was offered at the last edge but not taken.
    assign waiting = valid_q && !ready_q;

    always_comb begin
        evt.fire     = valid && ready;
        evt.drop     = waiting && !valid;
        evt.unstable = waiting && valid && (payload != pay_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ready_q <= 1'b0;
            pay_q   <= '0;
            count   <= '0;
        end else begin
            valid_q <= valid;
            ready_q <= ready;
            pay_q   <= payload;
            count   <= count + CNT_W'(evt.fire);
        end
    end

endmodule

// File: rtl/axl_pend_ctr.sv
module axl_pend_ctr #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic empty,
    output logic under,
    output logic over
);

    localparam logic [PEND_W-1:0] FULL = '1;

    logic [PEND_W-1:0] cnt;

    assign empty = (cnt == '0);
    assign under = dec && empty;
    assign over  = inc && !dec && (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec && !over) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc && !empty) begin
            cnt <= cnt - 1'b1;
        end else if (inc && dec && empty) begin
            // Response had nothing to retire; the new request still stands.
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/axl_err_sticky.sv
module axl_err_sticky
    import axl_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               any_valid,
    input  logic [ERR_NUM-1:0] live,
    output logic [ERR_NUM-1:0] flags,
    output logic               pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags                <= '0;
            flags[ERR_RST_VALID] <= any_valid;
            pulse                <= 1'b0;
        end else begin
            pulse <= |live;
            flags <= clr ? live : (flags | live);
        end
    end

endmodule

// File: rtl/axl_rule_mon.sv
module axl_rule_mon
    import axl_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PEND_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                err_clr,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [2:0]          arprot,
    input  logic                arvalid,
    input  logic                arready,
    input  logic [DATA_W-1:0]   rdata,
    input  logic [1:0]          rresp,
    input  logic                rvalid,
    input  logic                rready,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [2:0]          awprot,
    input  logic                awvalid,
    input  logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    input  logic                wready,
    input  logic [1:0]          bresp,
    input  logic                bvalid,
    input  logic                bready,
    output logic [ERR_NUM-1:0]  err_flags,
    output logic                err_any,
    output logic                err_pulse,
    output logic [CNT_W-1:0]    cnt_ar,
    output logic [CNT_W-1:0]    cnt_r,
    output logic [CNT_W-1:0]    cnt_aw,
    output logic [CNT_W-1:0]    cnt_w,
    output logic [CNT_W-1:0]    cnt_b
);

    localparam int STRB_W  = DATA_W / 8;
    localparam int A_PAY_W = ADDR_W + 3;
    localparam int R_PAY_W = DATA_W + 2;
    localparam int W_PAY_W = DATA_W + STRB_W;
    localparam int PAY_MAX = max2(max2(A_PAY_W, R_PAY_W), W_PAY_W);

    logic [CH_NUM-1:0]  vld;
    logic [CH_NUM-1:0]  rdy;
    logic [PAY_MAX-1:0] pay [CH_NUM];
    chan_evt_t          evt [CH_NUM];
    logic [CNT_W-1:0]   cnt [CH_NUM];

    assign vld = {bvalid, wvalid, awvalid, rvalid, arvalid};
    assign rdy = {bready, wready, awready, rready, arready};

    assign pay[IX_AR] = PAY_MAX'({arprot, araddr});
    assign pay[IX_R]  = PAY_MAX'({rresp, rdata});
    assign pay[IX_AW] = PAY_MAX'({awprot, awaddr});
    assign pay[IX_W]  = PAY_MAX'({wstrb, wdata});
    assign pay[IX_B]  = PAY_MAX'(bresp);

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        axl_chan_watch #(
            .PAY_W (PAY_MAX),
            .CNT_W (CNT_W)
        ) u_watch (
            .clk     (clk),
            .rst     (rst),
            .valid   (vld[c]),
            .ready   (rdy[c]),
            .payload (pay[c]),
            .evt     (evt[c]),
            .count   (cnt[c])
        );
    end

    assign cnt_ar = cnt[IX_AR];
    assign cnt_r  = cnt[IX_R];
    assign cnt_aw = cnt[IX_AW];
    assign cnt_w  = cnt[IX_W];
    assign cnt_b  = cnt[IX_B];

    logic rd_empty, rd_under, rd_over;
    logic aw_empty, aw_under, aw_over;
    logic wd_empty, wd_under, wd_over;

    axl_pend_ctr #(.PEND_W(PEND_W)) u_rd_pend (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt[IX_AR].fire),
        .dec   (evt[IX_R].fire),
        .empty (rd_empty),
        .under (rd_under),
        .over  (rd_over)
    );

    axl_pend_ctr #(.PEND_W(PEND_W)) u_aw_pend (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt[IX_AW].fire),
        .dec   (evt[IX_B].fire),
        .empty (aw_empty),
        .under (aw_under),
        .over  (aw_over)
    );

    axl_pend_ctr #(.PEND_W(PEND_W)) u_wd_pend (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt[IX_W].fire),
        .dec   (evt[IX_B].fire),
        .empty (wd_empty),
        .under (wd_under),
        .over  (wd_over)
    );

    // Masks every rule on the first edge after reset release.
    logic mask_q;
    always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b1;
        else     mask_q <= 1'b0;
    end

    logic [ERR_NUM-1:0] raw;
    logic [ERR_NUM-1:0] live;

    always_comb begin
        raw = '0;
        for (int c = 0; c < CH_NUM; c++) begin
            raw[ERR_DROP_BASE + c] = evt[c].drop;
            raw[ERR_UNST_BASE + c] = evt[c].unstable;
        end
        raw[ERR_RD_EARLY] = (rvalid && rd_empty) || rd_under;
        raw[ERR_WR_EARLY] = (bvalid && (aw_empty || wd_empty)) || aw_under || wd_under;
        raw[ERR_R_EXOK]   = rvalid && resp_illegal(rresp);
        raw[ERR_B_EXOK]   = bvalid && resp_illegal(bresp);
        raw[ERR_RD_DEEP]  = rd_over;
        raw[ERR_WR_DEEP]  = aw_over || wd_over;
        live = mask_q ? '0 : raw;
    end

    axl_err_sticky u_sticky (
        .clk       (clk),
        .rst       (rst),
        .clr       (err_clr),
        .any_valid (|vld),
        .live      (live),
        .flags     (err_flags),
        .pulse     (err_pulse)
    );

    assign err_any = |err_flags;

endmodule

// File: rtl/axl_rule_mon_chk.sv
module axl_rule_mon_chk
    import axl_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               err_clr,
    input logic               arvalid,
    input logic               arready,
    input logic               rvalid,
    input logic [1:0]         rresp,
    input logic [ERR_NUM-1:0] err_flags,
    input logic               err_any,
    input logic               err_pulse,
    input logic [CNT_W-1:0]   cnt_ar
);

    assert_pulse_has_flag_R10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_any);

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(err_clr)) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_ar_drop_flagged_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(arvalid) && !$past(arready) && !arvalid && !$past(rst)) |=> err_flags[ERR_DROP_BASE]);

    assert_rresp_exokay_R6: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rresp == 2'b01 && !$past(rst)) |=> err_flags[ERR_R_EXOK]);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_ar == $past(cnt_ar) || cnt_ar == $past(cnt_ar) + CNT_W'(1)));

endmodule

bind axl_rule_mon axl_rule_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_clr   (err_clr),
    .arvalid   (arvalid),
    .arready   (arready),
    .rvalid    (rvalid),
    .rresp     (rresp),
    .err_flags (err_flags),
    .err_any   (err_any),
    .err_pulse (err_pulse),
    .cnt_ar    (cnt_ar)
);

// File: tb/tb_axl_rule_mon.sv
`timescale 1ns/1ps
module tb_axl_rule_mon;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, err_clr = 1'b0;
    logic [31:0] araddr = '0, awaddr = '0, rdata = '0, wdata = '0;
    logic [2:0]  arprot = '0, awprot = '0;
    logic [3:0]  wstrb = '0;
    logic [1:0]  rresp = '0, bresp = '0;
    logic        arvalid = 0, arready = 0, rvalid = 0, rready = 0;
    logic        awvalid = 0, awready = 0, wvalid = 0, wready = 0;
    logic        bvalid = 0, bready = 0;
    logic [16:0] err_flags;
    logic        err_any, err_pulse;
    logic [15:0] cnt_ar, cnt_r, cnt_aw, cnt_w, cnt_b;

    axl_rule_mon dut (
        .clk(clk), .rst(rst), .err_clr(err_clr),
        .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .err_flags(err_flags), .err_any(err_any), .err_pulse(err_pulse),
        .cnt_ar(cnt_ar), .cnt_r(cnt_r), .cnt_aw(cnt_aw), .cnt_w(cnt_w), .cnt_b(cnt_b)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit model_on = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    logic [16:0] exp_flags = '0;
    logic        exp_pulse = 1'b0;
    int          exp_cnt [5];
    logic        pv [5];
    logic        pr [5];
    logic [63:0] pp [5];
    bit          masked = 1;
    int          rdq[$];
    int          awq[$];
    int          wq[$];

    function automatic logic v_of(input int c);
        case (c)
            0: return arvalid;
            1: return rvalid;
            2: return awvalid;
            3: return wvalid;
            default: return bvalid;
        endcase
    endfunction

    function automatic logic r_of(input int c);
        case (c)
            0: return arready;
            1: return rready;
            2: return awready;
            3: return wready;
            default: return bready;
        endcase
    endfunction

    function automatic logic [63:0] p_of(input int c);
        case (c)
            0: return 64'({arprot, araddr});
            1: return 64'({rresp, rdata});
            2: return 64'({awprot, awaddr});
            3: return 64'({wstrb, wdata});
            default: return 64'(bresp);
        endcase
    endfunction

    always @(posedge clk) begin
        logic [16:0] nw;
        logic        anyv;
        nw = '0;
        model_on = 1;
        anyv = arvalid | rvalid | awvalid | wvalid | bvalid;
        if (rst) begin
            exp_flags = {anyv, 16'h0};
            exp_pulse = 1'b0;
            rdq.delete(); awq.delete(); wq.delete();
            for (int c = 0; c < 5; c++) begin
                exp_cnt[c] = 0; pv[c] = 0; pr[c] = 0; pp[c] = '0;
            end
            masked = 1;
        end else begin
            for (int c = 0; c < 5; c++) begin
                if (pv[c] && !pr[c]) begin
                    if (!v_of(c)) nw[c] = 1'b1;
                    else if (p_of(c) != pp[c]) nw[5 + c] = 1'b1;
                end
            end
            if (rvalid && rdq.size() == 0) nw[10] = 1'b1;
            if (bvalid && (awq.size() == 0 || wq.size() == 0)) nw[11] = 1'b1;
            if (rvalid && rresp == 2'b01) nw[12] = 1'b1;
            if (bvalid && bresp == 2'b01) nw[13] = 1'b1;
            if (rvalid && rready) begin
                if (rdq.size() == 0) nw[10] = 1'b1; else void'(rdq.pop_front());
            end
            if (arvalid && arready) begin
                if (rdq.size() >= 15) nw[14] = 1'b1; else rdq.push_back(1);
            end
            if (bvalid && bready) begin
                if (awq.size() == 0) nw[11] = 1'b1; else void'(awq.pop_front());
                if (wq.size() == 0)  nw[11] = 1'b1; else void'(wq.pop_front());
            end
            if (awvalid && awready) begin
                if (awq.size() >= 15) nw[15] = 1'b1; else awq.push_back(1);
            end
            if (wvalid && wready) begin
                if (wq.size() >= 15) nw[15] = 1'b1; else wq.push_back(1);
            end
            for (int c = 0; c < 5; c++) begin
                if (v_of(c) && r_of(c)) exp_cnt[c] = (exp_cnt[c] + 1) % 65536;
                pv[c] = v_of(c); pr[c] = r_of(c); pp[c] = p_of(c);
            end
            if (masked) nw = '0;
            masked = 0;
            exp_pulse = |nw;
            exp_flags = err_clr ? nw : (exp_flags | nw);
        end
    end

    function automatic string tag_for(input int b);
        if (b < 5)   return "R2";
        if (b < 10)  return "R3";
        if (b == 10) return "R4";
        if (b == 11) return "R5";
        if (b < 14)  return "R6";
        if (b < 16)  return "R7";
        return "R8";
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (model_on && !done) begin
            n_tests++;
            if (err_flags !== exp_flags) begin
                n_fail++;
                for (int b = 0; b < 17; b++)
                    if (err_flags[b] !== exp_flags[b])
                        $display("FAIL %s flag bit %0d actual=%b expected=%b", tag_for(b), b, err_flags[b], exp_flags[b]);
            end
            n_tests++;
            if (err_pulse !== exp_pulse) begin
                n_fail++;
                $display("FAIL R10 err_pulse actual=%b expected=%b", err_pulse, exp_pulse);
            end
            n_tests++;
            if (err_any !== (|exp_flags)) begin
                n_fail++;
                $display("FAIL R9 err_any actual=%b expected=%b", err_any, |exp_flags);
            end
            n_tests++;
            if (cnt_ar !== 16'(exp_cnt[0]) || cnt_r !== 16'(exp_cnt[1]) || cnt_aw !== 16'(exp_cnt[2]) ||
                cnt_w !== 16'(exp_cnt[3]) || cnt_b !== 16'(exp_cnt[4])) begin
                n_fail++;
                $display("FAIL R1 counters actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
                         cnt_ar, cnt_r, cnt_aw, cnt_w, cnt_b,
                         exp_cnt[0], exp_cnt[1], exp_cnt[2], exp_cnt[3], exp_cnt[4]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        arvalid = 0; arready = 0; rvalid = 0; rready = 0;
        awvalid = 0; awready = 0; wvalid = 0; wready = 0;
        bvalid = 0; bready = 0; err_clr = 0;
        rresp = 2'b00; bresp = 2'b00;
    endtask

    task automatic clear_flags();
        idle(); err_clr = 1; tick(); err_clr = 0;
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(); rst = 1;
        repeat (3) tick();
        rst = 0; tick(); tick();
        chk("R8", "flags after reset", err_flags, 0);
        chk("R1", "cnt_ar after reset", cnt_ar, 0);

        // legal read with a wait state
        araddr = 32'h100; arvalid = 1; tick();
        arready = 1; tick();
        idle(); rvalid = 1; rready = 1; rdata = 32'hA5A5; tick();
        idle(); tick();
        chk("R4", "legal read raises nothing", err_flags, 0);
        chk("R1", "cnt_r after one read", cnt_r, 1);

        // legal write: data first, then request, then a held acknowledge
        wvalid = 1; wready = 1; wdata = 32'h11; wstrb = 4'hF; tick();
        idle(); awvalid = 1; awready = 1; awaddr = 32'h40; tick();
        idle(); bvalid = 1; tick();
        bready = 1; tick();
        idle(); tick();
        chk("R5", "legal write raises nothing", err_flags, 0);
        chk("R1", "cnt_b after one write", cnt_b, 1);

        // VALID dropped on read request
        arvalid = 1; tick();
        arvalid = 0; tick();
        chk("R2", "ar drop flag", err_flags[0], 1);
        chk("R10", "pulse after violation", err_pulse, 1);
        tick();
        chk("R10", "pulse lasts one cycle", err_pulse, 0);
        chk("R9", "flag stays set", err_flags[0], 1);
        chk("R9", "err_any set", err_any, 1);
        clear_flags(); tick();
        chk("R9", "flags after clear", err_flags, 0);

        // payload change on write data while stalled, then complete the write
        wvalid = 1; wdata = 32'h1; tick();
        wdata = 32'h2; tick();
        chk("R3", "w payload flag", err_flags[8], 1);
        wready = 1; tick();
        idle(); awvalid = 1; awready = 1; tick();
        idle(); bvalid = 1; bready = 1; tick();
        idle(); tick();
        chk("R5", "ordered write after unstable data", err_flags[11], 0);
        clear_flags();

        // read return with nothing outstanding
        rvalid = 1; rready = 1; tick();
        idle(); tick();
        chk("R4", "early read return", err_flags[10], 1);
        clear_flags();
        // return on the same edge as the request still counts as early
        arvalid = 1; arready = 1; rvalid = 1; rready = 1; tick();
        idle(); tick();
        chk("R4", "same-edge read return", err_flags[10], 1);
        clear_flags();
        rvalid = 1; rready = 1; tick();
        idle(); tick();
        chk("R4", "pending request answered cleanly", err_flags[10], 0);

        // acknowledge before write data
        awvalid = 1; awready = 1; tick();
        idle(); bvalid = 1; bready = 1; tick();
        idle(); tick();
        chk("R5", "acknowledge without data", err_flags[11], 1);
        clear_flags();

        // EXOKAY on read and on write acknowledge
        arvalid = 1; arready = 1; tick();
        idle(); rvalid = 1; rready = 1; rresp = 2'b01; tick();
        idle(); tick();
        chk("R6", "rresp 01 flag", err_flags[12], 1);
        chk("R6", "no ordering error", err_flags[10], 0);
        awvalid = 1; awready = 1; wvalid = 1; wready = 1; tick();
        idle(); bvalid = 1; bready = 1; bresp = 2'b10; tick();
        idle(); tick();
        chk("R6", "bresp 10 legal", err_flags[13], 0);
        awvalid = 1; awready = 1; wvalid = 1; wready = 1; tick();
        idle(); bvalid = 1; bready = 1; bresp = 2'b01; tick();
        idle(); tick();
        chk("R6", "bresp 01 flag", err_flags[13], 1);
        clear_flags();

        // 16 read requests with no return exceeds depth 15
        arvalid = 1; arready = 1;
        repeat (16) tick();
        idle(); tick();
        chk("R7", "read depth exceeded", err_flags[14], 1);
        clear_flags();
        rvalid = 1; rready = 1;
        repeat (15) tick();
        idle(); tick();
        chk("R7", "counter held at 15 drains cleanly", err_flags, 0);

        // VALID high during reset; violation in the masked cycle
        rst = 1; arvalid = 1; tick(); tick();
        rst = 0; arvalid = 0; rvalid = 1; rready = 1; tick();
        idle(); tick();
        chk("R8", "valid during reset flag", err_flags[16], 1);
        chk("R8", "masked cycle ignored", err_flags[10], 0);
        chk("R1", "masked cycle still counts", cnt_r, 1);
        clear_flags(); tick();
        chk("R9", "clear removes reset flag", err_flags, 0);

        // clear on the same edge as a new violation keeps it
        err_clr = 1; rvalid = 1; tick();
        idle(); tick();
        chk("R9", "clear edge loads new violation", err_flags[10], 1);
        clear_flags();

        // 65536 write data transfers wrap the counter
        wvalid = 1; wready = 1;
        repeat (65536) tick();
        idle(); tick();
        chk("R1", "cnt_w wraps to 0", cnt_w, 0);
        chk("R7", "write depth exceeded", err_flags[15], 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule